// File: doc/BRIEF.md
# Dynamic Address Assignment Target

This block is the target-side engine that lets a device on a two-wire serial bus obtain a 7-bit dynamic address and keep it. It sits behind a bit recovery front end. That front end supplies one strobe per bit slot with the sampled data level, plus separate pulses for start or repeated start and for stop. The block returns a single open-drain pull-down enable for the data line, the current dynamic address and a flag that says the address is valid.

After a broadcast header the block decodes the one-byte command code. Codes below 0x80 are broadcast to every target. Codes from 0x80 upward are directed, and they take effect only when a later header names this target. Three routes change the address. The first is the enter-assignment procedure: after each repeated start the controller sends the broadcast header with the read bit set. Every target that still has no address acknowledges it. The targets then shift out a 64-bit identity frame with zero-dominant arbitration, and the surviving target accepts the address byte the controller sends next. The second route assigns an address from a fixed static address. The third resets the address, either by broadcast or directed at one target.

The 4-bit instance field of the identity is captured from pins while reset is held. Identical devices strapped differently therefore arbitrate in a fixed order.

Top module: `daa_target`

## Requirements
- R1: While `rst` is high and after its release, `addr_valid`, `dyn_addr` and `sda_pull` are 0, and the instance field used in arbitration is the `inst_pins` value present during reset; later pin changes have no effect.
- R2: A header byte 0xFC (address 0x7E, write) is always acknowledged by pulling SDA in the ninth slot. The command byte that follows, sent MSB first, is obeyed only if its eight bits plus the ninth (T) bit hold an odd number of ones; otherwise it is ignored.
- R3: Command 0x07 enters assignment mode. In that mode a header byte 0xFD (address 0x7E, read) is acknowledged only while `addr_valid` is 0. Outside that mode, or while an address is held, SDA stays released in the ninth slot.
- R4: After acknowledging 0xFD the target sends 64 bits MSB first: the 48-bit identity then the bus-characteristics byte then the device-characteristics byte. Identity bits 47..33 hold the maker field, bit 32 is 0, bits 31..16 hold the part field, bits 15..12 hold the instance and bits 11..0 hold the low field. A 0 is sent by setting `sda_pull` to 1 and a 1 by releasing it.
- R5: If any sampled frame bit differs from the bit the target sent, the target releases SDA for the rest of that round, does not take the address byte, and competes again at the next 0xFD header.
- R6: The winner takes the next byte as {address[6:0], bit0}. When bit0 is 0 it pulls SDA in the ninth slot, and `addr_valid`=1 with the new `dyn_addr` is visible in the cycle after that slot is sampled. When bit0 is 1 it does not acknowledge and keeps its state. The address does not change while it stays valid.
- R7: Command 0x06 clears `addr_valid`. Command 0x86 followed by a header naming the current dynamic address with write is acknowledged and clears `addr_valid` at the ninth slot. A header naming any other address is not acknowledged.
- R8: Command 0x87 followed by a write header naming the static address is acknowledged only while `addr_valid` is 0. The next byte, with bit0 0, sets `dyn_addr` to bits 7..1 and raises `addr_valid`.
- R9: A stop ends assignment mode, cancels a pending directed command and releases SDA on the next cycle.
- R10: `sda_pull` changes only in the cycle after a bit strobe, start or stop. A start releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also loads the instance field |
| inst_pins | input | 4 | Strap value for the identity instance field |
| ev_start | input | 1 | One-cycle pulse for a start or repeated start |
| ev_stop | input | 1 | One-cycle pulse for a stop |
| bit_valid | input | 1 | One-cycle strobe marking a sampled bit slot |
| bit_in | input | 1 | Sampled data-line level for the strobed slot |
| sda_pull | output | 1 | Pull the data line low during the next slot |
| dyn_addr | output | 7 | Assigned dynamic address |
| addr_valid | output | 1 | Dynamic address is assigned |

## Verification
Every output is a register updated on the edge that samples a strobe. The pull-down for a slot is therefore already set when the next strobe is presented, and an address change is visible one cycle after the ninth-slot strobe. The bench spaces strobes two cycles apart and drives on the falling edge. The driver queues each expected drive level for the slot it is presenting, and each expected address state for the cycle right after the slot that changes it. The monitor compares on the falling edge, after that cycle's stimulus has settled. Arbitration is modelled by combining the controller bit, a simulated rival target's bit and the design's own pull on the wired-AND bus.

// File: rtl/daa_pkg.sv
package daa_pkg;
  localparam logic [6:0] BCAST_ADDR  = 7'h7E;
  localparam logic [7:0] CC_ENTER    = 8'h07;
  localparam logic [7:0] CC_RST_ALL  = 8'h06;
  localparam logic [7:0] CC_RST_DIR  = 8'h86;
  localparam logic [7:0] CC_STATIC   = 8'h87;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_CCC, ST_ARB, ST_DAA_ADDR, ST_STAT_ADDR, ST_SKIP
  } state_e;

  typedef enum logic [1:0] {PEND_NONE, PEND_RST, PEND_STAT} pend_e;

  typedef enum logic [2:0] {
    CMD_BAD, CMD_ENTER, CMD_RST_ALL, CMD_RST_DIR, CMD_STATIC, CMD_OTHER
  } cmd_e;

  typedef enum logic [2:0] {NX_SKIP, NX_CCC, NX_ARB, NX_STAT, NX_RSTD} next_e;
endpackage

// File: rtl/daa_ccc_decode.sv
module daa_ccc_decode
  import daa_pkg::*;
(
  input  logic [7:0] code,
  input  logic       tbit,
  output cmd_e       cmd
);
  logic odd_ok;
  assign odd_ok = ^{code, tbit};

  always_comb begin
    cmd = CMD_BAD;
    if (odd_ok) begin
      unique case (code)
        CC_ENTER:   cmd = CMD_ENTER;
        CC_RST_ALL: cmd = CMD_RST_ALL;
        CC_RST_DIR: cmd = CMD_RST_DIR;
        CC_STATIC:  cmd = CMD_STATIC;
        default:    cmd = CMD_OTHER;
      endcase
    end
  end
endmodule

// File: rtl/daa_hdr_decode.sv
module daa_hdr_decode
  import daa_pkg::*;
#(
  parameter int                ADDR_W      = 7,
  parameter logic [ADDR_W-1:0] STATIC_ADDR = 7'h3A
) (
  input  logic [ADDR_W:0]   hdr,
  input  logic              daa_mode,
  input  logic              addr_valid,
  input  logic [ADDR_W-1:0] dyn_addr,
  input  pend_e             pend,
  output logic              ack,
  output next_e             nxt
);
  localparam logic [ADDR_W-1:0] BC = ADDR_W'(BCAST_ADDR);

  logic [ADDR_W-1:0] a;
  logic              rd;
  assign a  = hdr[ADDR_W:1];
  assign rd = hdr[0];

  always_comb begin
    ack = 1'b0;
    nxt = NX_SKIP;
    if (a == BC) begin
      if (!rd) begin
        ack = 1'b1;
        nxt = NX_CCC;
      end else if (daa_mode && !addr_valid) begin
        ack = 1'b1;
        nxt = NX_ARB;
      end
    end else if (!rd && pend == PEND_STAT && !addr_valid && a == STATIC_ADDR) begin
      ack = 1'b1;
      nxt = NX_STAT;
    end else if (!rd && pend == PEND_RST && addr_valid && a == dyn_addr) begin
      ack = 1'b1;
      nxt = NX_RSTD;
    end
  end
endmodule

// File: rtl/daa_id_frame.sv
module daa_id_frame #(
  parameter int               MFG_W   = 15,
  parameter int               PART_W  = 16,
  parameter int               INST_W  = 4,
  parameter int               LOW_W   = 12,
  parameter int               CHR_W   = 8,
  parameter logic [MFG_W-1:0]  MFG_ID  = '0,
  parameter logic [PART_W-1:0] PART_ID = '0,
  parameter logic [LOW_W-1:0]  LOW_ID  = '0,
  parameter logic [CHR_W-1:0]  BUS_CHR = '0,
  parameter logic [CHR_W-1:0]  DEV_CHR = '0,
  localparam int ID_W    = MFG_W + 1 + PART_W + INST_W + LOW_W,
  localparam int FRAME_W = ID_W + 2 * CHR_W,
  localparam int IDX_W   = $clog2(FRAME_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INST_W-1:0] inst_pins,
  input  logic [IDX_W-1:0]  idx,
  output logic              bit_o
);
  localparam int POS_W = $clog2(FRAME_W);

  logic [INST_W-1:0]  inst_q;
  logic [FRAME_W-1:0] frame;
  logic [FRAME_W-1:0] frame_rev;

  always_ff @(posedge clk) begin
    if (rst) inst_q <= inst_pins;
  end

  assign frame = {MFG_ID, 1'b0, PART_ID, inst_q, LOW_ID, BUS_CHR, DEV_CHR};

  for (genvar i = 0; i < FRAME_W; i++) begin : g_rev
    assign frame_rev[i] = frame[FRAME_W-1-i];
  end

  assign bit_o = (idx < IDX_W'(FRAME_W)) ? frame_rev[idx[POS_W-1:0]] : 1'b1;
endmodule

// File: rtl/daa_target.sv
module daa_target
  import daa_pkg::*;
#(
  parameter int                ADDR_W      = 7,
  parameter logic [ADDR_W-1:0] STATIC_ADDR = 7'h3A,
  parameter int                MFG_W       = 15,
  parameter int                PART_W      = 16,
  parameter int                INST_W      = 4,
  parameter int                LOW_W       = 12,
  parameter int                CHR_W       = 8,
  parameter logic [MFG_W-1:0]  MFG_ID      = 15'h1A5B,
  parameter logic [PART_W-1:0] PART_ID     = 16'hC0DE,
  parameter logic [LOW_W-1:0]  LOW_ID      = 12'h35C,
  parameter logic [CHR_W-1:0]  BUS_CHR     = 8'h27,
  parameter logic [CHR_W-1:0]  DEV_CHR     = 8'h93
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INST_W-1:0] inst_pins,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              bit_valid,
  input  logic              bit_in,
  output logic              sda_pull,
  output logic [ADDR_W-1:0] dyn_addr,
  output logic              addr_valid
);
  localparam int ID_W     = MFG_W + 1 + PART_W + INST_W + LOW_W;
  localparam int FRAME_W  = ID_W + 2 * CHR_W;
  localparam int CNT_W    = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] C_LAST = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] C_NINE = CNT_W'(ADDR_W + 1);
  localparam logic [CNT_W-1:0] C_AEND = CNT_W'(FRAME_W - 1);

  state_e            st;
  pend_e             pend;
  next_e             nxt_q;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W:0]   sh;
  logic [ADDR_W:0]   byte_now;
  logic              daa_mode;
  logic              ack_q;
  logic [ADDR_W-1:0] cand;
  logic              pull_q;
  logic [ADDR_W-1:0] addr_q;
  logic              vld_q;

  logic              hdr_ack;
  next_e             hdr_nxt;
  cmd_e              cmd;
  logic [CNT_W-1:0]  id_idx;
  logic              id_bit;

  assign byte_now = {sh[ADDR_W-1:0], bit_in};
  assign id_idx   = (st == ST_ARB) ? cnt + CNT_W'(1) : '0;

  daa_hdr_decode #(.ADDR_W(ADDR_W), .STATIC_ADDR(STATIC_ADDR)) u_hdr (
    .hdr(byte_now), .daa_mode(daa_mode), .addr_valid(vld_q),
    .dyn_addr(addr_q), .pend(pend), .ack(hdr_ack), .nxt(hdr_nxt)
  );

  daa_ccc_decode u_ccc (.code(sh[7:0]), .tbit(bit_in), .cmd(cmd));

  daa_id_frame #(
    .MFG_W(MFG_W), .PART_W(PART_W), .INST_W(INST_W), .LOW_W(LOW_W),
    .CHR_W(CHR_W), .MFG_ID(MFG_ID), .PART_ID(PART_ID), .LOW_ID(LOW_ID),
    .BUS_CHR(BUS_CHR), .DEV_CHR(DEV_CHR)
  ) u_id (
    .clk(clk), .rst(rst), .inst_pins(inst_pins), .idx(id_idx), .bit_o(id_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      pend     <= PEND_NONE;
      nxt_q    <= NX_SKIP;
      cnt      <= '0;
      sh       <= '0;
      daa_mode <= 1'b0;
      ack_q    <= 1'b0;
      cand     <= '0;
      pull_q   <= 1'b0;
      addr_q   <= '0;
      vld_q    <= 1'b0;
    end else if (ev_stop) begin
      st       <= ST_IDLE;
      pend     <= PEND_NONE;
      daa_mode <= 1'b0;
      pull_q   <= 1'b0;
    end else if (ev_start) begin
      st     <= ST_HDR;
      cnt    <= '0;
      pull_q <= 1'b0;
    end else if (bit_valid) begin
      sh  <= byte_now;
      cnt <= cnt + CNT_W'(1);
      unique case (st)
        ST_HDR: begin
          if (cnt == C_LAST) begin
            pull_q <= hdr_ack;
            nxt_q  <= hdr_nxt;
            if (!hdr_ack) st <= ST_SKIP;
          end else if (cnt == C_NINE) begin
            cnt    <= '0;
            pull_q <= 1'b0;
            unique case (nxt_q)
              NX_CCC:  st <= ST_CCC;
              NX_ARB: begin
                st     <= ST_ARB;
                pull_q <= ~id_bit;
              end
              NX_STAT: st <= ST_STAT_ADDR;
              NX_RSTD: begin
                vld_q <= 1'b0;
                pend  <= PEND_NONE;
                st    <= ST_SKIP;
              end
              default: st <= ST_SKIP;
            endcase
          end
        end
        ST_CCC: begin
          if (cnt == C_NINE) begin
            st <= ST_SKIP;
            unique case (cmd)
              CMD_ENTER: begin
                daa_mode <= 1'b1;
                pend     <= PEND_NONE;
              end
              CMD_RST_ALL: begin
                vld_q    <= 1'b0;
                daa_mode <= 1'b0;
                pend     <= PEND_NONE;
              end
              CMD_RST_DIR: begin
                daa_mode <= 1'b0;
                pend     <= PEND_RST;
              end
              CMD_STATIC: begin
                daa_mode <= 1'b0;
                pend     <= PEND_STAT;
              end
              CMD_OTHER: begin
                daa_mode <= 1'b0;
                pend     <= PEND_NONE;
              end
              default: ;
            endcase
          end
        end
        ST_ARB: begin
          if (bit_in != ~pull_q) begin
            st     <= ST_SKIP;
            pull_q <= 1'b0;
          end else if (cnt == C_AEND) begin
            st     <= ST_DAA_ADDR;
            cnt    <= '0;
            pull_q <= 1'b0;
          end else begin
            pull_q <= ~id_bit;
          end
        end
        ST_DAA_ADDR: begin
          if (cnt == C_LAST) begin
            ack_q  <= ~byte_now[0];
            pull_q <= ~byte_now[0];
            cand   <= byte_now[ADDR_W:1];
          end else if (cnt == C_NINE) begin
            if (ack_q) begin
              addr_q <= cand;
              vld_q  <= 1'b1;
            end
            pull_q <= 1'b0;
            st     <= ST_SKIP;
          end
        end
        ST_STAT_ADDR: begin
          if (cnt == C_LAST) begin
            if (!byte_now[0]) begin
              addr_q <= byte_now[ADDR_W:1];
              vld_q  <= 1'b1;
            end
            pend <= PEND_NONE;
            st   <= ST_SKIP;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_pull   = pull_q;
  assign dyn_addr   = addr_q;
  assign addr_valid = vld_q;
endmodule

// File: rtl/daa_target_chk.sv
module daa_target_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              ev_start,
  input logic              ev_stop,
  input logic              bit_valid,
  input logic              sda_pull,
  input logic [ADDR_W-1:0] dyn_addr,
  input logic              addr_valid
);
  a_r9_stop_release: assert property (@(posedge clk) disable iff (rst)
    ev_stop |=> !sda_pull);

  a_r10_start_release: assert property (@(posedge clk) disable iff (rst)
    ev_start |=> !sda_pull);

  a_r10_pull_on_event: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull) |-> $past(bit_valid || ev_start || ev_stop));

  a_r6_valid_on_strobe: assert property (@(posedge clk) disable iff (rst)
    !$stable(addr_valid) |-> $past(bit_valid));

  a_r6_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && $past(addr_valid)) |-> $stable(dyn_addr));
endmodule

bind daa_target daa_target_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .ev_start(ev_start), .ev_stop(ev_stop),
  .bit_valid(bit_valid), .sda_pull(sda_pull), .dyn_addr(dyn_addr),
  .addr_valid(addr_valid)
);

// File: tb/daa_target_bench.sv
module daa_target_bench;
  localparam logic [14:0] MFG  = 15'h1A5B;
  localparam logic [15:0] PART = 16'hC0DE;
  localparam logic [11:0] LOW  = 12'h35C;
  localparam logic [7:0]  BCH  = 8'h27;
  localparam logic [7:0]  DCH  = 8'h93;
  localparam logic [6:0]  STAT = 7'h3A;
  localparam logic [3:0]  INST_RST = 4'hA;
  localparam logic [63:0] MY_FRAME  = {MFG, 1'b0, PART, INST_RST, LOW, BCH, DCH};
  localparam logic [63:0] RIVAL_LOW = {MFG, 1'b0, PART, 4'h3, LOW, BCH, DCH};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst = 1'b1, ev_start = 1'b0, ev_stop = 1'b0;
  logic       bit_valid = 1'b0, bit_in = 1'b1;
  logic [3:0] inst_pins = INST_RST;
  logic       sda_pull, addr_valid;
  logic [6:0] dyn_addr;

  daa_target #(.STATIC_ADDR(STAT), .MFG_ID(MFG), .PART_ID(PART), .LOW_ID(LOW),
               .BUS_CHR(BCH), .DEV_CHR(DCH)) u_daa_target (
    .clk(clk), .rst(rst), .inst_pins(inst_pins), .ev_start(ev_start),
    .ev_stop(ev_stop), .bit_valid(bit_valid), .bit_in(bit_in),
    .sda_pull(sda_pull), .dyn_addr(dyn_addr), .addr_valid(addr_valid)
  );

  typedef struct {
    int         due;
    int         kind;
    logic [7:0] val;
    string      tag;
  } item_t;

  item_t q[$];
  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input int kind, input logic [7:0] val, input string tag);
    item_t it;
    it.due = cyc; it.kind = kind; it.val = val; it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor: pops expected items and compares after the falling-edge stimulus
  always @(negedge clk) begin
    #1;
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = {7'd0, sda_pull};
        1: act = {7'd0, addr_valid};
        default: act = {1'b0, dyn_addr};
      endcase
      n_cmp++;
      if (act !== it.val) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual=%0h expected=%0h at cycle %0d",
                 it.tag, it.kind, act, it.val, cyc);
      end
    end
  end

  task automatic expect_out(input logic v, input logic [6:0] a, input string tag);
    @(negedge clk);
    push(1, {7'd0, v}, tag);
    if (v) push(2, {1'b0, a}, tag);
  endtask

  task automatic expect_pull(input logic p, input string tag);
    @(negedge clk);
    push(0, {7'd0, p}, tag);
  endtask

  task automatic slot(input logic c, input logic rb, input logic ep, input string tag);
    @(negedge clk);
    bit_in    = c & rb & ~sda_pull;
    bit_valid = 1'b1;
    push(0, {7'd0, ep}, tag);
    @(negedge clk);
    bit_valid = 1'b0;
    bit_in    = 1'b1;
  endtask

  task automatic start_c();
    @(negedge clk); ev_start = 1'b1;
    @(negedge clk); ev_start = 1'b0;
  endtask

  task automatic stop_c();
    @(negedge clk); ev_stop = 1'b1;
    @(negedge clk); ev_stop = 1'b0;
  endtask

  task automatic send_hdr(input logic [7:0] b, input logic ack, input string tag);
    for (int i = 7; i >= 0; i--) slot(b[i], 1'b1, 1'b0, tag);
    slot(1'b1, 1'b1, ack, tag);
  endtask

  task automatic ccc(input logic [7:0] code, input logic good, input string tag);
    start_c();
    send_hdr(8'hFC, 1'b1, "R2");
    for (int i = 7; i >= 0; i--) slot(code[i], 1'b1, 1'b0, tag);
    slot(good ? ~^code : ^code, 1'b1, 1'b0, tag);
  endtask

  task automatic daa_round(input logic exp_ack, input logic rv_on, input logic [7:0] abyte,
                           input string tag, output logic won);
    logic lost;
    won = 1'b0;
    start_c();
    send_hdr(8'hFD, exp_ack, "R3");
    if (exp_ack) begin
      lost = 1'b0;
      for (int k = 63; k >= 0; k--) begin
        logic mb, rb;
        mb = MY_FRAME[k];
        rb = rv_on ? RIVAL_LOW[k] : 1'b1;
        slot(1'b1, rb, lost ? 1'b0 : ~mb, tag);
        if (!lost && ((mb & rb) != mb)) lost = 1'b1;
      end
      for (int i = 7; i >= 0; i--) slot(abyte[i], 1'b1, 1'b0, tag);
      slot(1'b1, 1'b1, !lost && !abyte[0], tag);
      won = !lost && !abyte[0];
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic w;
    repeat (4) @(negedge clk);
    expect_out(1'b0, 7'd0, "R1 during reset");
    expect_pull(1'b0, "R1 during reset");
    rst = 1'b0;
    expect_out(1'b0, 7'd0, "R1 after reset");
    expect_pull(1'b0, "R1 after reset");

    // R3: 0x7E read header outside assignment mode is not acknowledged
    daa_round(1'b0, 1'b0, 8'h00, "R3", w);
    stop_c();

    // R2: enter command with bad parity is ignored
    ccc(8'h07, 1'b0, "R2");
    daa_round(1'b0, 1'b0, 8'h00, "R2", w);
    stop_c();

    // R9: stop ends assignment mode
    ccc(8'h07, 1'b1, "R9");
    stop_c();
    daa_round(1'b0, 1'b0, 8'h00, "R9", w);
    stop_c();

    // R5: lower rival wins first round; R1 pin change after reset ignored
    ccc(8'h07, 1'b1, "R3");
    daa_round(1'b1, 1'b1, 8'h40, "R5", w);
    expect_out(1'b0, 7'd0, "R5 loser stays unassigned");
    inst_pins = 4'h0;
    daa_round(1'b1, 1'b0, 8'h52, "R4 R1", w);
    expect_out(1'b1, 7'h29, "R6 assigned");
    daa_round(1'b0, 1'b0, 8'h00, "R3 assigned no ack", w);
    stop_c();

    // R7: broadcast reset clears the address
    ccc(8'h06, 1'b1, "R7");
    expect_out(1'b0, 7'd0, "R7 broadcast reset");
    stop_c();

    // R6: address byte with bit0 set is refused, next round accepted
    ccc(8'h07, 1'b1, "R6");
    daa_round(1'b1, 1'b0, 8'h53, "R6 bad bit0", w);
    expect_out(1'b0, 7'd0, "R6 refused");
    daa_round(1'b1, 1'b0, 8'h20, "R6", w);
    expect_out(1'b1, 7'h10, "R6 assigned 0x10");
    stop_c();

    // R7: directed reset only for own address
    ccc(8'h86, 1'b1, "R7");
    start_c();
    send_hdr(8'h22, 1'b0, "R7 other address");
    expect_out(1'b1, 7'h10, "R7 kept");
    start_c();
    send_hdr(8'h20, 1'b1, "R7 own address");
    expect_out(1'b0, 7'd0, "R7 directed reset");
    stop_c();

    // R9: pending static assignment cancelled by stop
    ccc(8'h87, 1'b1, "R9");
    stop_c();
    start_c();
    send_hdr({STAT, 1'b0}, 1'b0, "R9 pending cleared");
    stop_c();

    // R8: static-address assignment
    ccc(8'h87, 1'b1, "R8");
    start_c();
    send_hdr({STAT, 1'b0}, 1'b1, "R8 static ack");
    for (int i = 7; i >= 0; i--) slot(8'h4C >> i, 1'b1, 1'b0, "R8");
    expect_out(1'b1, 7'h26, "R8 assigned");
    stop_c();
    ccc(8'h87, 1'b1, "R8");
    start_c();
    send_hdr({STAT, 1'b0}, 1'b0, "R8 already assigned");
    expect_out(1'b1, 7'h26, "R8 unchanged");
    stop_c();

    // R10/R9: stop in mid-arbitration releases SDA
    ccc(8'h06, 1'b1, "R7");
    ccc(8'h07, 1'b1, "R10");
    start_c();
    send_hdr(8'hFD, 1'b1, "R3");
    expect_pull(~MY_FRAME[63], "R4 first frame bit");
    stop_c();
    expect_pull(1'b0, "R9 release on stop");

    repeat (4) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule